// File: doc/BRIEF.md
# Digital Silence Detector with Noise Test Output

This block watches a stereo sample stream and drives one flag pin. Once per frame the source delivers a left and a right sample word together with a one-cycle frame strobe. When both channels carry zero for a long unbroken run of frames, the flag rises. Board logic can use that flag to mute an output stage during digital silence. Any nonzero sample on either channel ends the run and drops the flag.

A small test register sits on a register write port. While it holds one chosen code, the flag pin stops showing the silence state. It shows instead the serial output of a free-running 24-bit pseudo-random generator. That generator steps once per advance tick, and the tick runs at 128 times the sample rate. The result is a white-noise test bit stream on the same pin. Any other register value gives the pin back to the silence detector.

Top module: `silence_noise_flag`

## Requirements
- R1: At each `frame_stb_i` where `left_i` and `right_i` are both zero, the silent-run count goes up by one. `flag_o` (in silence mode) goes high in the cycle after the edge that samples the 1024th such strobe in a row. After 1023 such strobes it is still low.
- R2: A strobe where either channel is nonzero (left only, right only, or both) sets the run count to zero. `flag_o` is low from the cycle after that edge. A fresh run of 1024 zero strobes is then needed to raise it again.
- R3: Once the run reaches 1024 it saturates. Any number of further zero strobes keeps `flag_o` high.
- R4: Sample values present in cycles without `frame_stb_i` have no effect on the run count or on `flag_o`.
- R5: The test register is 8 bits wide and answers at register address 511. It is written when `reg_we_i` is high and `reg_addr_i` equals 511. Writes to any other address leave it unchanged.
- R6: While the test register holds 7, `flag_o` equals bit 23 of the noise generator state. For any other value, `flag_o` shows the silence flag. The silence run keeps being tracked in both modes.
- R7: The noise generator is a 24-bit shift register. On each cycle with `noise_tick_i` high, the state becomes {state[22:0], fb}, where fb is the XOR of state bits 23, 22, 21 and 16. Without a tick the state holds. It steps whatever the mode is.
- R8: The noise generator state is never zero. Its sequence has period 2^24-1.
- R9: Under reset, the run count is 0, the test register is 0, the noise state is 24'hACE1B5, and `flag_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_stb_i | input | 1 | One-cycle strobe, one per frame, marking valid samples |
| left_i | input | 24 | Left channel sample |
| right_i | input | 24 | Right channel sample |
| noise_tick_i | input | 1 | Noise generator advance tick at 128x the sample rate |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 9 | Register write address |
| reg_wdata_i | input | 8 | Register write data |
| flag_o | output | 1 | Silence flag, or noise bit in test mode |

## Verification
Directed runs of exactly 1023 and 1024 zero strobes separate a correct run length from an off-by-one. Nonzero words are placed first on only the left and then on only the right channel, which shows that each channel alone can break a run. Nonzero samples placed between strobes, and long idle gaps, show that only strobed samples count. A random phase mixes sparse nonzero samples, random ticks and writes of 7, other values and wrong addresses. Comparing every cycle against a bench model of the counter, register and shift sequence catches tap, seed, mode-decode and address errors.

// File: rtl/snf_pkg.sv
package snf_pkg;
  parameter int SAMPLE_W   = 24;
  parameter int RUN_LEN    = 1024;
  parameter int LFSR_W     = 24;
  parameter logic [23:0] LFSR_TAPS = 24'hE10000;  // bits 23,22,21,16
  parameter logic [23:0] LFSR_SEED = 24'hACE1B5;
  parameter int ADDR_W     = 9;
  parameter int DATA_W     = 8;
  parameter int TEST_ADDR  = 511;
  parameter int NOISE_CODE = 7;
endpackage

// File: rtl/snf_run_counter.sv
module snf_run_counter #(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 1024,
  localparam int CNT_W   = $clog2(RUN_LEN + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                stb_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                silent_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);

  logic both_zero;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign both_zero = (left_i == '0) && (right_i == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (stb_i) begin
      if (!both_zero)          cnt_d = '0;
      else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;  // saturate at limit
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o    = cnt_q;
  assign silent_o = (cnt_q == LIMIT);
endmodule

// File: rtl/snf_lfsr.sv
module snf_lfsr #(
  parameter int          WIDTH = 24,
  parameter logic [WIDTH-1:0] TAPS = 24'hE10000,
  parameter logic [WIDTH-1:0] SEED = 24'hACE1B5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [WIDTH-1:0] state_o,
  output logic             bit_o
);
  logic [WIDTH-1:0] state_q;
  logic             fb;

  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (tick_i) state_q <= {state_q[WIDTH-2:0], fb};
  end

  assign state_o = state_q;
  assign bit_o   = state_q[WIDTH-1];
endmodule

// File: rtl/snf_test_reg.sv
module snf_test_reg #(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int TEST_ADDR  = 511,
  parameter int NOISE_CODE = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] value_o,
  output logic              noise_mode_o
);
  logic [DATA_W-1:0] value_q;
  logic              hit;

  assign hit = we_i && (addr_i == ADDR_W'(TEST_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  value_q <= '0;
    else if (hit) value_q <= wdata_i;
  end

  assign value_o      = value_q;
  assign noise_mode_o = (value_q == DATA_W'(NOISE_CODE));
endmodule

// File: rtl/silence_noise_flag.sv
module silence_noise_flag
  import snf_pkg::*;
#(
  parameter int SAMPLE_W_P = SAMPLE_W,
  parameter int RUN_LEN_P  = RUN_LEN,
  parameter int ADDR_W_P   = ADDR_W,
  parameter int DATA_W_P   = DATA_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  frame_stb_i,
  input  logic [SAMPLE_W_P-1:0] left_i,
  input  logic [SAMPLE_W_P-1:0] right_i,
  input  logic                  noise_tick_i,
  input  logic                  reg_we_i,
  input  logic [ADDR_W_P-1:0]   reg_addr_i,
  input  logic [DATA_W_P-1:0]   reg_wdata_i,
  output logic                  flag_o
);
  localparam int CNT_W = $clog2(RUN_LEN_P + 1);

  logic [CNT_W-1:0]    run_cnt;
  logic                silent;
  logic [LFSR_W-1:0]   lfsr_state;
  logic                noise_bit;
  logic [DATA_W_P-1:0] test_val;
  logic                noise_mode;

  snf_run_counter #(.SAMPLE_W(SAMPLE_W_P), .RUN_LEN(RUN_LEN_P)) u_run (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(frame_stb_i),
    .left_i(left_i), .right_i(right_i),
    .cnt_o(run_cnt), .silent_o(silent)
  );

  snf_lfsr #(.WIDTH(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(noise_tick_i),
    .state_o(lfsr_state), .bit_o(noise_bit)
  );

  snf_test_reg #(.ADDR_W(ADDR_W_P), .DATA_W(DATA_W_P),
                 .TEST_ADDR(TEST_ADDR), .NOISE_CODE(NOISE_CODE)) u_treg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .value_o(test_val), .noise_mode_o(noise_mode)
  );

  assign flag_o = noise_mode ? noise_bit : silent;
endmodule

// File: rtl/snf_checker.sv
module snf_checker #(
  parameter int CNT_W   = 11,
  parameter int RUN_LEN = 1024,
  parameter int LFSR_W  = 24,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 9,
  parameter int SAMPLE_W = 24
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                frame_stb_i,
  input logic [SAMPLE_W-1:0] left_i,
  input logic [SAMPLE_W-1:0] right_i,
  input logic                noise_tick_i,
  input logic                reg_we_i,
  input logic [ADDR_W-1:0]   reg_addr_i,
  input logic                flag_o,
  input logic [CNT_W-1:0]    run_cnt,
  input logic [LFSR_W-1:0]   lfsr_state,
  input logic [DATA_W-1:0]   test_val,
  input logic                noise_mode
);
  logic treg_hit;
  assign treg_hit = reg_we_i && (reg_addr_i == ADDR_W'(511));

  AST_BREAK_DROPS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_stb_i && (left_i != '0 || right_i != '0) && !noise_mode && !treg_hit)
      |=> !flag_o); // R2

  AST_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt <= CNT_W'(RUN_LEN)); // R3

  AST_CNT_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_stb_i |=> $stable(run_cnt)); // R4

  AST_TREG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !treg_hit |=> $stable(test_val)); // R5

  AST_LFSR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !noise_tick_i |=> $stable(lfsr_state)); // R7

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_state != '0); // R8
endmodule

bind silence_noise_flag snf_checker #(
  .CNT_W(CNT_W), .RUN_LEN(RUN_LEN_P), .LFSR_W(snf_pkg::LFSR_W),
  .DATA_W(DATA_W_P), .ADDR_W(ADDR_W_P), .SAMPLE_W(SAMPLE_W_P)
) u_snf_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_stb_i(frame_stb_i),
  .left_i(left_i), .right_i(right_i), .noise_tick_i(noise_tick_i),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .flag_o(flag_o),
  .run_cnt(run_cnt), .lfsr_state(lfsr_state), .test_val(test_val),
  .noise_mode(noise_mode)
);

// File: tb/test_silence_noise_flag.sv
module test_silence_noise_flag;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_stb_i = 1'b0;
  logic [23:0] left_i = '0;
  logic [23:0] right_i = '0;
  logic        noise_tick_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [8:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic        flag_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int          m_cnt;
  logic [23:0] m_lfsr;
  logic [7:0]  m_treg;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  silence_noise_flag i_silence_noise_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_stb_i(frame_stb_i),
    .left_i(left_i), .right_i(right_i), .noise_tick_i(noise_tick_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .flag_o(flag_o)
  );

  function automatic logic [23:0] lfsr_next(input logic [23:0] s);
    return {s[22:0], s[23] ^ s[22] ^ s[21] ^ s[16]};
  endfunction

  function automatic logic model_flag();
    if (m_treg == 8'd7) return m_lfsr[23];
    return (m_cnt == 1024);
  endfunction

  task automatic check(input string req, input logic exp);
    checks++;
    if (flag_o !== exp) begin
      failures++;
      $display("FAIL %s flag_o actual=%b expected=%b at %0t", req, flag_o, exp, $time);
    end
  endtask

  // Drive one cycle, update model at the edge, compare after the edge.
  task automatic step(input string req, input logic stb, input logic [23:0] l,
                      input logic [23:0] r, input logic tick, input logic we,
                      input logic [8:0] addr, input logic [7:0] data, input bit chk);
    frame_stb_i = stb; left_i = l; right_i = r; noise_tick_i = tick;
    reg_we_i = we; reg_addr_i = addr; reg_wdata_i = data;
    @(posedge clk_i);
    if (stb) begin
      if (l == '0 && r == '0) begin
        if (m_cnt < 1024) m_cnt++;
      end else m_cnt = 0;
    end
    if (tick) m_lfsr = lfsr_next(m_lfsr);
    if (we && addr == 9'd511) m_treg = data;
    #(CLK_PERIOD/4);
    if (chk) check(req, model_flag());
  endtask

  task automatic idle(input string req, input logic [23:0] junk);
    step(req, 1'b0, junk, ~junk, 1'b0, 1'b0, 9'd0, 8'd0, 1'b1);
  endtask

  task automatic zero_frames(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      step(req, 1'b1, '0, '0, 1'b0, 1'b0, 9'd0, 8'd0, 1'b0);
      if (i % 3 == 0) idle("R4", 24'h123456);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_cnt = 0; m_lfsr = 24'hACE1B5; m_treg = 8'd0;
    #(CLK_PERIOD * 3);
    check("R9 reset", 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 after reset", 1'b0);

    // R1: 1023 then 1024
    zero_frames("R1", 1023);
    check("R1 after 1023", 1'b0);
    step("R1 1024th", 1'b1, '0, '0, 1'b0, 1'b0, 9'd0, 8'd0, 1'b1);
    check("R1 expect high", 1'b1);
    idle("R4 gap keeps flag", 24'hFFFFFF);

    // R3 saturation
    zero_frames("R3", 2000);
    check("R3 saturated", 1'b1);

    // R2 left only
    step("R2 left break", 1'b1, 24'h000001, '0, 1'b0, 1'b0, 9'd0, 8'd0, 1'b1);
    check("R2 low after left", 1'b0);
    zero_frames("R2", 1023);
    check("R2 rerun 1023", 1'b0);
    step("R2 rerun 1024", 1'b1, '0, '0, 1'b0, 1'b0, 9'd0, 8'd0, 1'b1);
    // R2 right only
    step("R2 right break", 1'b1, '0, 24'h800000, 1'b0, 1'b0, 9'd0, 8'd0, 1'b1);
    check("R2 low after right", 1'b0);
    zero_frames("R2", 1024);
    check("R2 high again", 1'b1);

    // R5: wrong address ignored
    step("R5 wrong addr", 1'b0, '0, '0, 1'b0, 1'b1, 9'd510, 8'd7, 1'b1);
    for (int i = 0; i < 30; i++)
      step("R5 wrong addr hold", 1'b0, '0, '0, 1'b1, 1'b0, 9'd0, 8'd0, 1'b1);
    check("R5 still silence flag", 1'b1);

    // R6/R7 noise mode
    step("R6 enter noise", 1'b0, '0, '0, 1'b0, 1'b1, 9'd511, 8'd7, 1'b1);
    for (int i = 0; i < 200; i++)
      step("R7 noise seq", 1'b0, '0, '0, 1'($urandom_range(0, 1)), 1'b0, 9'd0, 8'd0, 1'b1);
    step("R6 other code", 1'b0, '0, '0, 1'b1, 1'b1, 9'd511, 8'd15, 1'b1);
    check("R6 back to silence", 1'b1);
    step("R6 code 0", 1'b0, '0, '0, 1'b0, 1'b1, 9'd511, 8'd0, 1'b1);

    // Random phase, R1-related mix
    for (int i = 0; i < 40000; i++) begin
      logic stb, tick, we, nz;
      logic [23:0] l, r;
      logic [8:0] a;
      logic [7:0] d;
      stb  = ($urandom_range(0, 1) == 0);
      nz   = ($urandom_range(0, 1499) == 0);
      l    = nz && $urandom_range(0, 1) ? 24'($urandom_range(1, 24'hFFFFFF)) : '0;
      r    = nz && l == '0 ? 24'($urandom_range(1, 24'hFFFFFF)) : '0;
      if (!stb) begin l = 24'($urandom); r = 24'($urandom); end
      tick = ($urandom_range(0, 3) == 0);
      we   = ($urandom_range(0, 599) == 0);
      a    = ($urandom_range(0, 2) == 0) ? 9'($urandom_range(0, 510)) : 9'd511;
      d    = ($urandom_range(0, 1) == 0) ? 8'd7 : 8'($urandom);
      step("R6 R7 R1 random", stb, l, r, tick, we, a, d, 1'b1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule